// File: doc/BRIEF.md
# Packet DMA Channel Register Block

This block holds the software-visible registers of a two-channel packet DMA engine for ATA disks. A simple memory-mapped bus writes each channel's control word, descriptor count, next-descriptor pointer, lookup pointer and the two FIFO thresholds. From those registers the block drives the engine's control lines: a one-cycle start pulse for the packet fetcher, a one-cycle engine-reset pulse, a level hard-reset for the attached device, and the PIO timing mode.

The engine reports events on a per-channel event bus. Each event sets sticky bits in that channel's status byte. A read of the status byte clears it. A channel raises its interrupt line while its status is nonzero and its control word does not mask it. Start commands are refused until software has armed a global lock register with a key value. This guards the engine against a stray start after power-up.

Top module: `pktdma_chan_regs`

## Requirements
- R1: After reset, each channel's control word reads 0x0103 (interrupt masked, bits 1:0 = 3). The count reads 1 and both FIFO thresholds read 0x0100. Pointers and status read 0, the pulses, hard-reset and interrupt outputs are low, and pio_mode is 3.
- R2: Channel c decodes at byte address 0x80 + 0x20*c. Within a channel, the offsets are: control 0x00 (16 bit), status 0x02 (8 bit), count 0x04 (16 bit), next pointer 0x0C (32 bit), lookup pointer 0x10 (32 bit), input threshold 0x14 (16 bit) and output threshold 0x16 (16 bit). Write data and read data are right-aligned. Read data appears on bus_rdata in the cycle after the read strobe. Unmapped reads return 0 and unmapped writes change nothing.
- R3: Bits 2:0 of the next pointer always read 0, whatever is written, so the pointer stays 8-byte aligned.
- R4: Writing 0x07 to byte address 0xC7 arms the start lock, and writing any other value there disarms it. The lock reads back 0x07 when armed and 0 otherwise.
- R5: A control write with bit 7 = 1, bit 5 = 0 while the lock is armed raises go_pulse for exactly the one cycle after the write. Bit 7 always reads back 0. With the lock disarmed, the write gives no pulse.
- R6: A control write with bit 5 = 1 raises eng_rst for the one cycle after the write, clears the status byte and suppresses any start. Bit 5 reads back 0.
- R7: Control bit 2 drives dev_hrst as a level, and control bits 1:0 drive that channel's pio_mode field.
- R8: Each 1 on evt_set sets the matching status bit (bit 0 error, bit 4 unexpected interrupt, bit 6 packet error, other bits as driven). Bits stay set until cleared. Writes to the status offset have no effect.
- R9: A status read returns the current value and clears the byte. An event arriving in the same cycle as the read is kept in the status byte and is not in the returned value.
- R10: irq of a channel is high when its status is nonzero and control bit 8 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Registered read data |
| evt_set | input | 16 | Per-channel status set bits, 8 per channel |
| go_pulse | output | 2 | Per-channel start pulse |
| eng_rst | output | 2 | Per-channel engine reset pulse |
| dev_hrst | output | 2 | Per-channel device hard reset level |
| irq | output | 2 | Per-channel interrupt |
| pio_mode | output | 4 | Per-channel PIO mode, 2 bits each |
| cpb_count | output | 32 | Per-channel descriptor count, 16 bits each |
| cpb_next | output | 64 | Per-channel next-descriptor pointer |
| cpb_lookup | output | 64 | Per-channel lookup pointer |
| fifo_in_thr | output | 32 | Per-channel input FIFO threshold |
| fifo_out_thr | output | 32 | Per-channel output FIFO threshold |

## Verification
The hardest case to reach is an engine event that lands in the same cycle as a status read. The read must return the old value while the new bit stays behind. The bench's read task can pulse evt_set during the read strobe, and a directed step uses it to check both the returned data and the next read. Random traffic also mixes lock arm and disarm writes with control writes. This covers start commands against both lock states and combined start-and-reset words.

// File: rtl/pktdma_chan_regs.sv
module pktdma_chan_regs #(
  parameter int NCH       = 2,
  parameter int AW        = 8,
  parameter int CH_BASE   = 'h80,
  parameter int CH_STRIDE = 'h20,
  parameter int LOCK_ADDR = 'hC7,
  parameter logic [7:0]  LOCK_KEY = 8'h07,
  parameter logic [15:0] CTRL_RST = 16'h0103,
  parameter logic [15:0] THR_RST  = 16'h0100,
  parameter logic [15:0] CNT_RST  = 16'h0001
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [AW-1:0]        bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NCH*8-1:0]     evt_set,
  output logic [NCH-1:0]       go_pulse,
  output logic [NCH-1:0]       eng_rst,
  output logic [NCH-1:0]       dev_hrst,
  output logic [NCH-1:0]       irq,
  output logic [NCH*2-1:0]     pio_mode,
  output logic [NCH*16-1:0]    cpb_count,
  output logic [NCH*32-1:0]    cpb_next,
  output logic [NCH*32-1:0]    cpb_lookup,
  output logic [NCH*16-1:0]    fifo_in_thr,
  output logic [NCH*16-1:0]    fifo_out_thr
);
  localparam int OW = $clog2(CH_STRIDE);
  localparam int IW = AW - OW;
  localparam logic [AW:0] WIN_LO = (AW+1)'(CH_BASE);
  localparam logic [AW:0] WIN_HI = (AW+1)'(CH_BASE + NCH * CH_STRIDE);
  localparam logic [OW-1:0] O_CTRL = OW'('h00);
  localparam logic [OW-1:0] O_STAT = OW'('h02);
  localparam logic [OW-1:0] O_CNT  = OW'('h04);
  localparam logic [OW-1:0] O_NXT  = OW'('h0C);
  localparam logic [OW-1:0] O_LKP  = OW'('h10);
  localparam logic [OW-1:0] O_FIN  = OW'('h14);
  localparam logic [OW-1:0] O_FOUT = OW'('h16);
  localparam int B_MASK = 8;
  localparam int B_GO   = 7;
  localparam int B_ERST = 5;
  localparam int B_HRST = 2;
  localparam logic [15:0] CTRL_KEEP = ~((16'd1 << B_GO) | (16'd1 << B_ERST));

  logic                     lock;
  logic                     in_win;
  logic                     lock_hit;
  logic [AW-1:0]            rel;
  logic [OW-1:0]            off;
  logic [NCH-1:0]           hit;
  logic [NCH-1:0][31:0]     chan_rd;
  logic [31:0]              rmux;

  assign in_win   = ({1'b0, bus_addr} >= WIN_LO) && ({1'b0, bus_addr} < WIN_HI);
  assign lock_hit = (bus_addr == AW'(LOCK_ADDR));
  assign rel      = bus_addr - AW'(CH_BASE);
  assign off      = rel[OW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      lock <= 1'b0;
    else if (bus_wr && lock_hit)
      lock <= (bus_wdata[7:0] == LOCK_KEY);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [15:0] ctrl, cnt, fin, fout;
    logic [7:0]  stat;
    logic [31:0] nxt, lkp;
    logic        gop, erp;
    logic        wr_c, rd_c, ctl_wr;
    logic [7:0]  evt;

    assign hit[g]  = in_win && (rel[AW-1:OW] == IW'(g));
    assign wr_c    = bus_wr && hit[g];
    assign rd_c    = bus_rd && hit[g];
    assign ctl_wr  = wr_c && (off == O_CTRL);
    assign evt     = evt_set[g*8 +: 8];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl <= CTRL_RST;
        cnt  <= CNT_RST;
        nxt  <= '0;
        lkp  <= '0;
        fin  <= THR_RST;
        fout <= THR_RST;
        gop  <= 1'b0;
        erp  <= 1'b0;
      end else begin
        gop <= ctl_wr && bus_wdata[B_GO] && !bus_wdata[B_ERST] && lock;
        erp <= ctl_wr && bus_wdata[B_ERST];
        if (wr_c) begin
          case (off)
            O_CTRL: ctrl <= bus_wdata[15:0] & CTRL_KEEP;
            O_CNT:  cnt  <= bus_wdata[15:0];
            O_NXT:  nxt  <= {bus_wdata[31:3], 3'b000};
            O_LKP:  lkp  <= bus_wdata;
            O_FIN:  fin  <= bus_wdata[15:0];
            O_FOUT: fout <= bus_wdata[15:0];
            default: ;
          endcase
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        stat <= '0;
      else if (ctl_wr && bus_wdata[B_ERST])
        stat <= '0;
      else if (rd_c && off == O_STAT)
        stat <= evt;
      else
        stat <= stat | evt;
    end

    assign chan_rd[g] = (off == O_CTRL) ? {16'h0, ctrl} :
                        (off == O_STAT) ? {24'h0, stat} :
                        (off == O_CNT)  ? {16'h0, cnt}  :
                        (off == O_NXT)  ? nxt           :
                        (off == O_LKP)  ? lkp           :
                        (off == O_FIN)  ? {16'h0, fin}  :
                        (off == O_FOUT) ? {16'h0, fout} : 32'h0;

    assign go_pulse[g]           = gop;
    assign eng_rst[g]            = erp;
    assign dev_hrst[g]           = ctrl[B_HRST];
    assign irq[g]                = (stat != 8'h00) && !ctrl[B_MASK];
    assign pio_mode[g*2 +: 2]    = ctrl[1:0];
    assign cpb_count[g*16 +: 16] = cnt;
    assign cpb_next[g*32 +: 32]  = nxt;
    assign cpb_lookup[g*32 +: 32] = lkp;
    assign fifo_in_thr[g*16 +: 16]  = fin;
    assign fifo_out_thr[g*16 +: 16] = fout;
  end

  always_comb begin
    rmux = 32'h0;
    if (lock_hit)
      rmux = {24'h0, lock ? LOCK_KEY : 8'h00};
    for (int i = 0; i < NCH; i++)
      if (hit[i])
        rmux = chan_rd[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rmux;
  end
endmodule

// File: rtl/pktdma_chan_regs_chk.sv
module pktdma_chan_regs_chk #(
  parameter int NCH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              lock,
  input logic [NCH-1:0]    go_pulse,
  input logic [NCH-1:0]    eng_rst,
  input logic [NCH-1:0]    irq,
  input logic [NCH*16-1:0] cpb_count,
  input logic [NCH*32-1:0] cpb_next,
  input logic [NCH*16-1:0] fifo_in_thr
);
  a_r5_go_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (|go_pulse) |-> ($past(lock) && $past(bus_wr)));

  a_r6_no_go_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pulse & eng_rst) == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_a
    a_r6_reset_quiets_irq: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rst[g] |-> !irq[g]);
  end

  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> ($stable(cpb_count) && $stable(cpb_next) && $stable(fifo_in_thr)));

  a_r5_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|go_pulse) && !$past(bus_wr) |-> 1'b0);
endmodule

bind pktdma_chan_regs pktdma_chan_regs_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .lock(lock),
  .go_pulse(go_pulse), .eng_rst(eng_rst), .irq(irq),
  .cpb_count(cpb_count), .cpb_next(cpb_next), .fifo_in_thr(fifo_in_thr)
);

// File: tb/sim_pktdma_chan_regs.sv
module sim_pktdma_chan_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] evt_set = '0;
  logic [1:0]  go_pulse, eng_rst, dev_hrst, irq;
  logic [3:0]  pio_mode;
  logic [31:0] cpb_count, fifo_in_thr, fifo_out_thr;
  logic [63:0] cpb_next, cpb_lookup;

  pktdma_chan_regs u0 (.*);

  always #2 clk = ~clk;

  int vecs = 0, errs = 0;
  logic [15:0] m_ctrl [2], m_cnt [2], m_fin [2], m_fout [2];
  logic [7:0]  m_stat [2];
  logic [31:0] m_nxt [2], m_lkp [2];
  logic        m_lock;
  logic [1:0]  e_go, e_er;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int c, o;
    if (a == 8'hC7) return m_lock ? 32'h7 : 32'h0;
    if (a < 8'h80 || a >= 8'hC0) return 32'h0;
    c = (a - 8'h80) >> 5;
    o = (a - 8'h80) & 31;
    case (o)
      'h00: return {16'h0, m_ctrl[c]};
      'h02: return {24'h0, m_stat[c]};
      'h04: return {16'h0, m_cnt[c]};
      'h0C: return m_nxt[c];
      'h10: return m_lkp[c];
      'h14: return {16'h0, m_fin[c]};
      'h16: return {16'h0, m_fout[c]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_reset();
    for (int c = 0; c < 2; c++) begin
      m_ctrl[c] = 16'h0103; m_cnt[c] = 16'h1; m_fin[c] = 16'h100; m_fout[c] = 16'h100;
      m_stat[c] = 0; m_nxt[c] = 0; m_lkp[c] = 0;
    end
    m_lock = 0;
  endtask

  task automatic check_outs();
    for (int c = 0; c < 2; c++) begin
      chk(irq[c], (m_stat[c] != 0) && !m_ctrl[c][8], "R10 irq");
      chk(dev_hrst[c], m_ctrl[c][2], "R7 dev_hrst");
      chk(pio_mode[c*2 +: 2], m_ctrl[c][1:0], "R7 pio_mode");
      chk(cpb_count[c*16 +: 16], m_cnt[c], "R2 cpb_count");
      chk(cpb_next[c*32 +: 32], m_nxt[c], "R3 cpb_next");
      chk(cpb_lookup[c*32 +: 32], m_lkp[c], "R2 cpb_lookup");
      chk(fifo_in_thr[c*16 +: 16], m_fin[c], "R2 fifo_in_thr");
      chk(fifo_out_thr[c*16 +: 16], m_fout[c], "R2 fifo_out_thr");
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    int c, o;
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    e_go = 0; e_er = 0;
    if (a == 8'hC7) m_lock = (d[7:0] == 8'h07);
    else if (a >= 8'h80 && a < 8'hC0) begin
      c = (a - 8'h80) >> 5;
      o = (a - 8'h80) & 31;
      case (o)
        'h00: begin
          e_go[c] = d[7] && !d[5] && m_lock;
          e_er[c] = d[5];
          m_ctrl[c] = d[15:0] & 16'hFF5F;
          if (d[5]) m_stat[c] = 0;
        end
        'h04: m_cnt[c] = d[15:0];
        'h0C: m_nxt[c] = {d[31:3], 3'b000};
        'h10: m_lkp[c] = d;
        'h14: m_fin[c] = d[15:0];
        'h16: m_fout[c] = d[15:0];
        default: ;
      endcase
    end
    chk(go_pulse, e_go, "R5 go_pulse");
    chk(eng_rst, e_er, "R6 eng_rst");
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [15:0] ev, input string req);
    logic [31:0] exp;
    @(negedge clk);
    bus_rd = 1; bus_addr = a; evt_set = ev;
    exp = m_read(a);
    @(negedge clk);
    bus_rd = 0; evt_set = 0;
    chk(bus_rdata, exp, req);
    for (int c = 0; c < 2; c++) begin
      if (a == 8'h82 + 8'(c * 32)) m_stat[c] = ev[c*8 +: 8];
      else m_stat[c] = m_stat[c] | ev[c*8 +: 8];
    end
  endtask

  task automatic do_evt(input logic [15:0] ev);
    @(negedge clk);
    evt_set = ev;
    @(negedge clk);
    evt_set = 0;
    for (int c = 0; c < 2; c++) m_stat[c] = m_stat[c] | ev[c*8 +: 8];
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] offs [8];
    offs = '{8'h00, 8'h02, 8'h04, 8'h0C, 8'h10, 8'h14, 8'h16, 8'h1A};
    void'($urandom(32'h5EED_0042));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(go_pulse, 0, "R1 go_pulse"); chk(eng_rst, 0, "R1 eng_rst");
    check_outs();
    do_rd(8'h80, 0, "R1 ctrl reset");
    do_rd(8'hA4, 0, "R1 count reset");
    do_rd(8'hB6, 0, "R1 out threshold reset");
    // R2 unmapped
    do_wr(8'h40, 32'hFFFF_FFFF);
    do_rd(8'h40, 0, "R2 unmapped read");
    do_rd(8'h9A, 0, "R2 hole read");
    // R5 go without lock
    do_wr(8'h80, 32'h0000_0083);
    // R4 arm lock, R5 go
    do_wr(8'hC7, 32'h07);
    do_rd(8'hC7, 0, "R4 lock armed");
    do_wr(8'hA0, 32'h0000_0083);
    @(negedge clk); chk(go_pulse, 0, "R5 pulse one cycle");
    do_rd(8'hA0, 0, "R5 go reads 0");
    // R6 reset with go: no start
    do_wr(8'h80, 32'h0000_01A3);
    do_rd(8'h80, 0, "R6 erst reads 0");
    // R3 alignment
    do_wr(8'h8C, 32'h1234_567F);
    do_rd(8'h8C, 0, "R3 pointer aligned");
    // R7 hard reset and pio
    do_wr(8'hA0, 32'h0000_0006);
    check_outs();
    // R8 events sticky, status write ignored; R10 irq
    do_evt(16'h1051);
    do_wr(8'hA2, 32'h0);
    check_outs();
    // R9 read clears, same-cycle event kept
    do_rd(8'hA2, 16'h4000, "R9 status read");
    do_rd(8'hA2, 0, "R9 late event kept");
    do_rd(8'hA2, 0, "R9 cleared");
    // R6 reset clears status
    do_rd(8'h82, 0, "R8 status ch0");
    do_evt(16'h0011);
    do_wr(8'h80, 32'h0000_0020);
    do_rd(8'h82, 0, "R6 status cleared");
    // R4 disarm
    do_wr(8'hC7, 32'h05);
    do_rd(8'hC7, 0, "R4 lock disarmed");
    do_wr(8'h80, 32'h0000_0080);
    check_outs();
    // random traffic
    for (int n = 0; n < 800; n++) begin
      int op;
      logic [7:0] a;
      op = $urandom % 10;
      a = 8'h80 + 8'(($urandom % 2) * 32) + offs[$urandom % 8];
      if (op < 3) do_wr(a, $urandom);
      else if (op < 4) do_wr(8'h80 + 8'(($urandom % 2) * 32), $urandom & 32'h1A7);
      else if (op < 7) do_rd(a, ($urandom % 4 == 0) ? 16'($urandom) : 16'h0,
                             (a[4:0] == 5'h02) ? "R9 random status" : "R2 random read");
      else if (op < 8) do_evt(16'($urandom) & 16'h5151);
      else if (op < 9) do_wr(8'hC7, ($urandom % 2) ? 32'h7 : 32'($urandom % 8));
      else do_rd(8'hC7, 0, "R4 random lock");
      check_outs();
    end
    finish_run();
  end
endmodule